// File: doc/BRIEF.md
# SMBus Host Block-Transfer Buffer

This block is the byte store that sits between a host controller's register port and its SMBus block-transfer engine. Before a block write, software loads the payload by writing the block data register again and again; each write lands in the next entry. After a block read, software empties the store by reading the same register repeatedly. The length of the block lives in a separate count register. Software writes it before a block write, and the engine captures it from the first byte a slave returns on a block read.

A host-side pointer selects the entry that the block data register reaches. Any read of the control register rewinds that pointer to entry zero. Software relies on this side effect to start filling or draining at the top. The engine has its own pointer, which it rewinds at the start of each transfer. The engine steps that pointer as it consumes outgoing bytes or stores incoming ones. Both pointers stop at the last entry instead of wrapping.

The store is switched on by a buffer-enable bit in an auxiliary control register. That register also holds a hardware error-check enable bit. When the store is off, the block data register falls back to a single holding byte that serves a byte-at-a-time handshake. A build without the store reads the buffer-enable bit back as zero, so software can detect that the store is missing.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset the count register reads 0, the auxiliary register reads 0x00, the count-valid flag is 0 and both pointers are at entry 0.
- R2: With the store enabled, each host write to the block data register stores `hst_wdata` at the entry the host pointer selects, and each host read returns that entry on `hst_rdata` in the same cycle. Either access advances the host pointer by one.
- R3: A control-register read pulse (`hst_ctl_rd`) sets the host pointer to entry 0 on the next clock. This takes priority over any advance in the same cycle.
- R4: The host pointer stops at entry DEPTH-1 (31 by default). Further accesses all reach entry 31: a 33rd write overwrites entry 31, and reads past the end keep returning entry 31.
- R5: `eng_start` sets the engine pointer to entry 0. `eng_rdata` shows the entry the engine pointer selects, and each `eng_rd` pulse with the store enabled advances the pointer, so a block write sends entries 0 to count-1 in order.
- R6: With the store enabled, each `eng_wr` pulse stores `eng_wdata` at the engine pointer and advances it, so received bytes fill entries from 0 upward. An engine write takes priority over a host write to the same entry.
- R7: The count register (`hst_cnt`) takes `hst_cnt_wdata` on `hst_cnt_wr` and takes `eng_cnt_wdata` on `eng_cnt_wr`; the engine wins if both pulse together. `cnt_ok` is 1 exactly when the count, read as an unsigned byte, lies in 1..32.
- R8: `eng_last` is 1 exactly when `cnt_ok` is 1 and the engine pointer equals count-1.
- R9: Auxiliary control: bit 0 is the error-check enable (`pec_en`) and bit 1 is the buffer enable (`buf_en`). `aux_rdata` returns those two bits with bits 7:2 reading 0. With `BUF_SUPPORT`=0, bit 1 always reads 0.
- R10: With the store disabled, the block data register is a single holding byte shared by the host and the engine. Accesses do not move either pointer and do not touch the store's entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_wr | input | 1 | Write strobe for auxiliary control |
| aux_wdata | input | 8 | Auxiliary control write data |
| aux_rdata | output | 8 | Auxiliary control read value |
| pec_en | output | 1 | Error-check enable bit |
| buf_en | output | 1 | Store enable bit |
| hst_ctl_rd | input | 1 | Control-register read pulse (rewinds host pointer) |
| hst_blk_wr | input | 1 | Host write to block data register |
| hst_blk_rd | input | 1 | Host read of block data register |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Block data register read value |
| hst_cnt_wr | input | 1 | Host write to count register |
| hst_cnt_wdata | input | CW | Host count value |
| hst_cnt | output | CW | Count register value |
| eng_start | input | 1 | Engine transfer start (rewinds engine pointer) |
| eng_rd | input | 1 | Engine consumes one outgoing byte |
| eng_wr | input | 1 | Engine stores one received byte |
| eng_wdata | input | DW | Received byte from engine |
| eng_rdata | output | DW | Outgoing byte to engine |
| eng_cnt_wr | input | 1 | Engine captures received count |
| eng_cnt_wdata | input | CW | Received count value |
| cnt_ok | output | 1 | Count lies in 1..32 |
| eng_last | output | 1 | Engine pointer is at the final byte of the block |

## Verification
The bench overruns the host pointer with 33 writes and then reads past the end. A pointer that wrapped would overwrite entry 0 and return the first byte again, instead of leaving entry 31 holding the last value. It rewinds the host pointer partway through a drain, which catches a control read that is ignored or that loses to the advance. It probes the count limits at 0, 1, 32, 33 and 255, where an off-by-one or a signed compare would misreport `cnt_ok` or raise `eng_last` for an illegal length. It also runs holding-byte traffic with the store disabled and then re-enables the store. A design that still stepped the pointer or wrote the store would return the wrong first entry. A build without the store must keep reporting the enable bit as zero.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;

  // next pointer value, holding at top instead of wrapping
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

  // a legal block length is 1..depth
  function automatic logic len_legal(input int unsigned len, input int unsigned depth);
    return (len != 0) && (len <= depth);
  endfunction

  // pointer sits on the final byte of a legal block
  function automatic logic at_final(input int unsigned ptr, input int unsigned len,
                                    input int unsigned depth);
    return len_legal(len, depth) && (ptr + 1 == len);
  endfunction

endpackage

// File: rtl/smb_blkbuf_ptr.sv
module smb_blkbuf_ptr #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  import smb_blkbuf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= IW'(sat_next(32'(ptr), DEPTH - 1));
  end
endmodule

// File: rtl/smb_blkbuf_mem.sv
module smb_blkbuf_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [IW-1:0] a_idx,
  input  logic [DW-1:0] a_d,
  output logic [DW-1:0] a_q,
  input  logic          b_we,
  input  logic [IW-1:0] b_idx,
  input  logic [DW-1:0] b_d,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (b_we && b_idx == IW'(g))      ent[g] <= b_d;
      else if (a_we && a_idx == IW'(g)) ent[g] <= a_d;
    end
  end

  assign a_q = ent[a_idx];
  assign b_q = ent[b_idx];
endmodule

// File: rtl/smb_blkbuf_aux.sv
module smb_blkbuf_aux #(
  parameter bit BUF_SUPPORT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       pec_en,
  output logic       buf_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pec_en <= 1'b0;
      buf_en <= 1'b0;
    end else if (wr) begin
      pec_en <= wdata[0];
      buf_en <= wdata[1] & BUF_SUPPORT;
    end
  end

  assign rdata = {6'b0, buf_en, pec_en};
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int DEPTH       = 32,
  parameter int DW          = 8,
  parameter int CW          = 8,
  parameter bit BUF_SUPPORT = 1'b1,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aux_wr,
  input  logic [7:0]    aux_wdata,
  output logic [7:0]    aux_rdata,
  output logic          pec_en,
  output logic          buf_en,
  input  logic          hst_ctl_rd,
  input  logic          hst_blk_wr,
  input  logic          hst_blk_rd,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  input  logic          hst_cnt_wr,
  input  logic [CW-1:0] hst_cnt_wdata,
  output logic [CW-1:0] hst_cnt,
  input  logic          eng_start,
  input  logic          eng_rd,
  input  logic          eng_wr,
  input  logic [DW-1:0] eng_wdata,
  output logic [DW-1:0] eng_rdata,
  input  logic          eng_cnt_wr,
  input  logic [CW-1:0] eng_cnt_wdata,
  output logic          cnt_ok,
  output logic          eng_last
);
  import smb_blkbuf_pkg::*;

  // named internal events, visible to the bound checker
  logic          host_step;
  logic          eng_step;
  logic [IW-1:0] host_idx;
  logic [IW-1:0] eng_idx;
  logic [DW-1:0] store_hq;
  logic [DW-1:0] store_eq;
  logic [DW-1:0] hold_q;
  logic [CW-1:0] cnt_q;

  smb_blkbuf_aux #(.BUF_SUPPORT(BUF_SUPPORT)) u_aux (
    .clk(clk), .rst_n(rst_n), .wr(aux_wr), .wdata(aux_wdata),
    .rdata(aux_rdata), .pec_en(pec_en), .buf_en(buf_en)
  );

  assign host_step = buf_en & (hst_blk_wr | hst_blk_rd);
  assign eng_step  = buf_en & (eng_rd | eng_wr);

  smb_blkbuf_ptr #(.DEPTH(DEPTH)) u_hptr (
    .clk(clk), .rst_n(rst_n), .clr(hst_ctl_rd), .adv(host_step), .ptr(host_idx)
  );

  smb_blkbuf_ptr #(.DEPTH(DEPTH)) u_eptr (
    .clk(clk), .rst_n(rst_n), .clr(eng_start), .adv(eng_step), .ptr(eng_idx)
  );

  smb_blkbuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk),
    .a_we(buf_en & hst_blk_wr), .a_idx(host_idx), .a_d(hst_wdata), .a_q(store_hq),
    .b_we(buf_en & eng_wr),     .b_idx(eng_idx),  .b_d(eng_wdata), .b_q(store_eq)
  );

  // single holding byte used while the store is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hold_q <= '0;
    else if (!buf_en && eng_wr)      hold_q <= eng_wdata;
    else if (!buf_en && hst_blk_wr)  hold_q <= hst_wdata;
  end

  // block length register, engine capture wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (eng_cnt_wr) cnt_q <= eng_cnt_wdata;
    else if (hst_cnt_wr) cnt_q <= hst_cnt_wdata;
  end

  assign hst_rdata = buf_en ? store_hq : hold_q;
  assign eng_rdata = buf_en ? store_eq : hold_q;
  assign hst_cnt   = cnt_q;
  assign cnt_ok    = len_legal(32'(cnt_q), DEPTH);
  assign eng_last  = at_final(32'(eng_idx), 32'(cnt_q), DEPTH);
endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          buf_en,
  input logic          hst_ctl_rd,
  input logic          hst_blk_wr,
  input logic          hst_blk_rd,
  input logic          eng_start,
  input logic [IW-1:0] host_idx,
  input logic [IW-1:0] eng_idx
);
  localparam logic [IW-1:0] TOP = IW'(DEPTH - 1);

  // R3
  host_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ctl_rd |=> host_idx == '0);

  // R2
  host_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hst_ctl_rd && buf_en && (hst_blk_wr || hst_blk_rd) && host_idx != TOP)
      |=> host_idx == $past(host_idx) + IW'(1));

  // R4
  host_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hst_ctl_rd && host_idx == TOP) |=> host_idx == TOP);

  // R10
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hst_ctl_rd && !buf_en) |=> $stable(host_idx));

  // R5
  eng_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> eng_idx == '0);
endmodule

bind smb_blkbuf smb_blkbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .hst_ctl_rd(hst_ctl_rd),
  .hst_blk_wr(hst_blk_wr), .hst_blk_rd(hst_blk_rd), .eng_start(eng_start),
  .host_idx(host_idx), .eng_idx(eng_idx)
);

// File: tb/smb_blkbuf_tb.sv
module smb_blkbuf_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aux_wr = 0, hst_ctl_rd = 0, hst_blk_wr = 0, hst_blk_rd = 0;
  logic       hst_cnt_wr = 0, eng_start = 0, eng_rd = 0, eng_wr = 0, eng_cnt_wr = 0;
  logic [7:0] aux_wdata = 0, hst_wdata = 0, hst_cnt_wdata = 0, eng_wdata = 0, eng_cnt_wdata = 0;
  logic [7:0] aux_rdata, hst_rdata, hst_cnt, eng_rdata;
  logic       pec_en, buf_en, cnt_ok, eng_last;

  logic       n_aux_wr = 0;
  logic [7:0] n_aux_wdata = 0;
  logic [7:0] n_aux_rdata, n_hrd, n_cnt, n_erd;
  logic       n_pec, n_buf, n_ok, n_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_blkbuf u_dut (
    .clk, .rst_n, .aux_wr, .aux_wdata, .aux_rdata, .pec_en, .buf_en,
    .hst_ctl_rd, .hst_blk_wr, .hst_blk_rd, .hst_wdata, .hst_rdata,
    .hst_cnt_wr, .hst_cnt_wdata, .hst_cnt, .eng_start, .eng_rd, .eng_wr,
    .eng_wdata, .eng_rdata, .eng_cnt_wr, .eng_cnt_wdata, .cnt_ok, .eng_last
  );

  smb_blkbuf #(.BUF_SUPPORT(1'b0)) u_dut_nobuf (
    .clk, .rst_n, .aux_wr(n_aux_wr), .aux_wdata(n_aux_wdata), .aux_rdata(n_aux_rdata),
    .pec_en(n_pec), .buf_en(n_buf), .hst_ctl_rd(1'b0), .hst_blk_wr(1'b0),
    .hst_blk_rd(1'b0), .hst_wdata(8'h00), .hst_rdata(n_hrd), .hst_cnt_wr(1'b0),
    .hst_cnt_wdata(8'h00), .hst_cnt(n_cnt), .eng_start(1'b0), .eng_rd(1'b0),
    .eng_wr(1'b0), .eng_wdata(8'h00), .eng_rdata(n_erd), .eng_cnt_wr(1'b0),
    .eng_cnt_wdata(8'h00), .cnt_ok(n_ok), .eng_last(n_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic aux_set(input logic [7:0] v);
    aux_wr = 1; aux_wdata = v; step(); aux_wr = 0;
  endtask

  task automatic ctl_read();
    hst_ctl_rd = 1; step(); hst_ctl_rd = 0;
  endtask

  task automatic hwrite(input logic [7:0] v);
    hst_blk_wr = 1; hst_wdata = v; step(); hst_blk_wr = 0;
  endtask

  task automatic hread(output logic [7:0] v);
    hst_blk_rd = 1; #1 v = hst_rdata; step(); hst_blk_rd = 0;
  endtask

  task automatic set_cnt(input logic [7:0] v);
    hst_cnt_wr = 1; hst_cnt_wdata = v; step(); hst_cnt_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", hst_cnt, 0);
    chk("R1 aux", aux_rdata, 0);
    chk("R1 cnt_ok", cnt_ok, 0);
    chk("R1 host entry", hst_rdata, 0);
  endtask

  task automatic t_aux();
    aux_set(8'hFF);
    chk("R9 aux read", aux_rdata, 8'h03);
    chk("R9 pec_en", pec_en, 1);
    n_aux_wr = 1; n_aux_wdata = 8'hFF; step(); n_aux_wr = 0;
    chk("R9 no-store build", n_aux_rdata, 8'h01);
    aux_set(8'h02);
    chk("R9 buf only", aux_rdata, 8'h02);
  endtask

  task automatic t_fill_drain();
    logic [7:0] v;
    ctl_read();
    for (int i = 0; i < 5; i++) hwrite(8'h10 + 8'(i));
    ctl_read();
    for (int i = 0; i < 5; i++) begin
      hread(v);
      chk("R2 drain", v, 8'h10 + i);
    end
    ctl_read();
    hread(v); hread(v);
    ctl_read();
    hread(v);
    chk("R3 rewind mid-drain", v, 8'h10);
    // rewind wins over simultaneous access
    hst_ctl_rd = 1; hst_blk_rd = 1; step(); hst_ctl_rd = 0; hst_blk_rd = 0;
    hread(v);
    chk("R3 rewind priority", v, 8'h10);
  endtask

  task automatic t_saturate();
    logic [7:0] v;
    ctl_read();
    for (int i = 0; i < 33; i++) hwrite(8'(i) + 8'h40);
    ctl_read();
    hread(v);
    chk("R4 entry0 intact", v, 8'h40);
    for (int i = 1; i < 32; i++) hread(v);
    chk("R4 last entry overwritten", v, 8'h40 + 32);
    hread(v);
    chk("R4 read past end", v, 8'h40 + 32);
  endtask

  task automatic t_eng_send();
    ctl_read();
    for (int i = 0; i < 4; i++) hwrite(8'hA0 + 8'(i));
    set_cnt(8'd4);
    chk("R7 host count", hst_cnt, 4);
    eng_start = 1; step(); eng_start = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R5 engine byte", eng_rdata, 8'hA0 + i);
      chk("R8 last flag", eng_last, (i == 3) ? 1 : 0);
      eng_rd = 1; step(); eng_rd = 0;
    end
  endtask

  task automatic t_eng_recv();
    logic [7:0] v;
    eng_start = 1; step(); eng_start = 0;
    eng_cnt_wr = 1; eng_cnt_wdata = 8'd3; hst_cnt_wr = 1; hst_cnt_wdata = 8'd9;
    step(); eng_cnt_wr = 0; hst_cnt_wr = 0;
    chk("R7 engine capture wins", hst_cnt, 3);
    chk("R7 cnt_ok", cnt_ok, 1);
    for (int i = 0; i < 3; i++) begin
      eng_wr = 1; eng_wdata = 8'hC0 + 8'(i); step(); eng_wr = 0;
    end
    ctl_read();
    for (int i = 0; i < 3; i++) begin
      hread(v);
      chk("R6 received byte", v, 8'hC0 + i);
    end
  endtask

  task automatic t_bounds();
    set_cnt(8'd0);   chk("R7 count 0", cnt_ok, 0);
    set_cnt(8'd1);   chk("R7 count 1", cnt_ok, 1);
    eng_start = 1; step(); eng_start = 0;
    chk("R8 last at count 1", eng_last, 1);
    set_cnt(8'd32);  chk("R7 count 32", cnt_ok, 1);
    set_cnt(8'd33);  chk("R7 count 33", cnt_ok, 0);
    chk("R8 no last for 33", eng_last, 0);
    set_cnt(8'd255); chk("R7 count 255", cnt_ok, 0);
    set_cnt(8'd0);
    chk("R8 no last for 0", eng_last, 0);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    ctl_read();
    hwrite(8'h11); hwrite(8'h22);
    ctl_read();
    aux_set(8'h00);
    hwrite(8'h33); hwrite(8'h44);
    hread(v);
    chk("R10 holding byte", v, 8'h44);
    hread(v);
    chk("R10 holding byte repeat", v, 8'h44);
    eng_wr = 1; eng_wdata = 8'h5A; step(); eng_wr = 0;
    hread(v);
    chk("R10 engine to holding", v, 8'h5A);
    hwrite(8'h77);
    chk("R10 holding to engine", eng_rdata, 8'h77);
    aux_set(8'h02);
    hread(v);
    chk("R10 store untouched, pointer held", v, 8'h11);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_aux();
    t_fill_drain();
    t_saturate();
    t_eng_send();
    t_eng_recv();
    t_bounds();
    t_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule